// File: doc/BRIEF.md
# Fractional Clock Rate Generator

This block turns a free-running parent clock into a clock-enable stream whose average rate is a fraction N/32 of the parent rate. Downstream logic runs on the parent clock and advances only in cycles where the enable is high. This removes ("swallows") 32 − N of every 32 parent pulses. N is 32 minus a 5-bit rate field, so a field of zero leaves the parent rate untouched and a field of 31 keeps one pulse in 32. Within any window of 32 cycles, an accumulator spreads the kept pulses as evenly as it can.

Software reaches the block through a small word-wide register port that holds two words. The rate word carries the rate field. The update word carries a commit flag in its top bit. Writing the rate word only stages a value. The value reaches the pulse generator after software raises the commit flag. The hardware then waits for the next 32-cycle frame boundary and loads the new multiplier there. On the following cycle it drops the flag, and software polls for that as the completion signal. While the flag is up, writes to the rate word are dropped, so a staged value cannot change under a pending update.

The update sequencer has three named states:

- **ST_IDLE** (no update pending). On a raised flag it moves to ST_WAIT. If the flag arrives on the last cycle of a frame, it commits at once and goes straight to ST_DONE.
- **ST_WAIT** (flag raised, frame not yet finished). It moves to ST_DONE on the last frame cycle, which is the commit.
- **ST_DONE**. It clears the flag and always returns to ST_IDLE.

Top module: `frac_clk_gen`

## Requirements
- R1: After synchronous active-high reset, both register words read 0 and the enable is high in every cycle (full rate).
- R2: The rate word sits at address 0, with the rate field in bits 12:8. Once a committed value has settled, any 32 consecutive cycles contain exactly N = 32 − field enable pulses.
- R3: The distance between two consecutive enable pulses is always floor(32/N) or ceil(32/N) cycles.
- R4: Writing the rate word without raising the commit flag leaves the enable pattern unchanged.
- R5: The commit flag is bit 31 of the update word at address 1. Writing a 1 there raises it. The hardware clears it between 2 and 33 cycles after the write, and by then the new rate is in force.
- R6: Writing 0 to bit 31 of the update word while the flag is raised does not lower it.
- R7: A write to the rate word while the flag is raised is dropped: the readback is unchanged and the committed rate comes from the earlier value.
- R8: All bits of both words other than the rate field and the flag read back as last written and do not affect the rate.
- R9: A new multiplier is loaded only at a 32-cycle frame boundary, and the flag clears on the next cycle. Successive completion times therefore differ by a multiple of 32 cycles.
- R10: A rate field of 31 gives a single enable pulse per 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (4) | Word address: 0 rate word, 1 update word |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr, combinational |
| clk_en | output | 1 | Pulse-swallowed clock enable |

## Verification
The rate path is tried with field values 0, 16, 31, 5, 20, 3 and 8. These give multipliers of 32, 16, 1, 27, 12, 29 and 24. Each one is counted over a 32-cycle window and its pulse gaps are measured over 64 cycles:

- The extremes (every cycle, one pulse per frame) separate a stuck or inverted carry from a correct one.
- The uneven ratios (27, 12, 29) expose clustering in the spread.

Register traffic covers several cases:

- staging without a commit;
- garbage in the unused bits;
- a clear-attempt and a rate write issued while an update is pending, timed just after a completion so the flag is known to still be up.

Completion times are compared to one another modulo 32 to show that updates land only on frame boundaries.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } upd_state_t;

endpackage

// File: rtl/fcg_regs.sv
module fcg_regs #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int FIELD_W   = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter int RATE_ADDR = 0,
    parameter int UPD_ADDR  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               kick_clear,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] field,
    output logic               kick
);

    localparam logic [ADDR_W-1:0] RATE_A = ADDR_W'(RATE_ADDR);
    localparam logic [ADDR_W-1:0] UPD_A  = ADDR_W'(UPD_ADDR);

    logic [DATA_W-1:0] rate_q;
    logic [DATA_W-1:0] upd_q;
    logic [DATA_W-1:0] upd_d;
    logic              wr_rate;
    logic              wr_upd;

    assign wr_rate = wr_en && (addr == RATE_A);
    assign wr_upd  = wr_en && (addr == UPD_A);

    // flag: hardware clear, software set; a set in the clearing cycle wins (R5, R6)
    always_comb begin
        upd_d = upd_q;
        if (wr_upd) begin
            upd_d = wdata;
        end
        upd_d[KICK_BIT] = (upd_q[KICK_BIT] & ~kick_clear) | (wr_upd & wdata[KICK_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            upd_q  <= '0;
        end else begin
            // rate word frozen while an update is pending (R7)
            if (wr_rate && !upd_q[KICK_BIT]) begin
                rate_q <= wdata;
            end
            upd_q <= upd_d;
        end
    end

    always_comb begin
        if (addr == RATE_A) begin
            rdata = rate_q;
        end else if (addr == UPD_A) begin
            rdata = upd_q;
        end else begin
            rdata = '0;
        end
    end

    assign field = rate_q[FIELD_LSB +: FIELD_W];
    assign kick  = upd_q[KICK_BIT];

endmodule

// File: rtl/fcg_update_fsm.sv
module fcg_update_fsm (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic frame_last,
    output logic commit,
    output logic kick_clear
);

    import fcg_pkg::*;

    upd_state_t state_q;
    upd_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kick) begin
                    state_d = frame_last ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (frame_last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: load at the frame boundary (R9), drop the flag one cycle later
    always_comb begin
        commit     = 1'b0;
        kick_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: commit     = kick & frame_last;
            ST_WAIT: commit     = frame_last;
            ST_DONE: kick_clear = 1'b1;
            default: begin
                commit     = 1'b0;
                kick_clear = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fcg_swallow.sv
module fcg_swallow #(
    parameter int FIELD_W = 5,
    localparam int MULT_W = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [FIELD_W-1:0] field,
    output logic               frame_last,
    output logic               clk_en,
    output logic [MULT_W-1:0]  mult
);

    localparam int FRAME = 1 << FIELD_W;
    localparam logic [MULT_W-1:0] FULL = MULT_W'(FRAME);

    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] acc_q;
    logic [MULT_W-1:0]  mult_q;
    logic [MULT_W-1:0]  sum;
    logic               en_q;

    // carry out of the modulo-FRAME accumulator marks a kept pulse (R2, R3)
    assign sum        = MULT_W'(acc_q) + mult_q;
    assign frame_last = (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            mult_q <= FULL;
            en_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            en_q  <= sum[FIELD_W];
            if (commit) begin
                mult_q <= FULL - MULT_W'(field);
                acc_q  <= '0;
            end else begin
                acc_q  <= sum[FIELD_W-1:0];
            end
        end
    end

    assign clk_en = en_q;
    assign mult   = mult_q;

endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int FIELD_W   = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter int RATE_ADDR = 0,
    parameter int UPD_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);

    localparam int MULT_W = FIELD_W + 1;

    logic [FIELD_W-1:0] field_w;
    logic               kick_w;
    logic               kick_clear_w;
    logic               commit_w;
    logic               frame_last_w;
    logic [MULT_W-1:0]  mult_w;

    fcg_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .FIELD_W  (FIELD_W),
        .FIELD_LSB(FIELD_LSB),
        .KICK_BIT (KICK_BIT),
        .RATE_ADDR(RATE_ADDR),
        .UPD_ADDR (UPD_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .kick_clear(kick_clear_w),
        .rdata     (reg_rdata),
        .field     (field_w),
        .kick      (kick_w)
    );

    fcg_update_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick_w),
        .frame_last(frame_last_w),
        .commit    (commit_w),
        .kick_clear(kick_clear_w)
    );

    fcg_swallow #(
        .FIELD_W(FIELD_W)
    ) u_swallow (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit_w),
        .field     (field_w),
        .frame_last(frame_last_w),
        .clk_en    (clk_en),
        .mult      (mult_w)
    );

endmodule

// File: rtl/fcg_chk.sv
module fcg_chk #(
    parameter int FIELD_W = 5,
    localparam int MULT_W = FIELD_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               kick,
    input logic               kick_clear,
    input logic               commit,
    input logic               frame_last,
    input logic [FIELD_W-1:0] field,
    input logic [MULT_W-1:0]  mult,
    input logic               clk_en
);

    localparam logic [MULT_W-1:0] FULL = MULT_W'(1 << FIELD_W);

    p_commit_on_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        commit |-> frame_last);

    p_clear_after_commit_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> kick_clear);

    p_field_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        kick |=> $stable(field));

    p_kick_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (kick && !kick_clear) |=> kick);

    p_mult_held_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(mult));

    p_full_rate_r1: assert property (@(posedge clk) disable iff (rst)
        (mult == FULL) |=> clk_en);

    p_clear_single_r5: assert property (@(posedge clk) disable iff (rst)
        kick_clear |=> !kick_clear);

endmodule

bind frac_clk_gen fcg_chk #(
    .FIELD_W(FIELD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .kick      (kick_w),
    .kick_clear(kick_clear_w),
    .commit    (commit_w),
    .frame_last(frame_last_w),
    .field     (field_w),
    .mult      (mult_w),
    .clk_en    (clk_en)
);

// File: tb/sim_frac_clk_gen.sv
`timescale 1ns/1ps
module sim_frac_clk_gen;

    localparam logic [3:0]  RATE = 4'd0;
    localparam logic [3:0]  UPD  = 4'd1;
    localparam logic [31:0] KICK = 32'h8000_0000;

    typedef struct {
        int    n;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clk_en;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 0;
    bit   mon_busy = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    frac_clk_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (wr),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .clk_en   (clk_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    // polls the flag; latency counted in edges after the write edge
    task automatic wait_clear(input string req, output int when);
        int lat = 0;
        addr = UPD;
        forever begin
            @(negedge clk);
            lat++;
            if (!rdata[31] || lat > 40) break;
        end
        check(lat >= 2 && lat <= 33, req, "flag clear latency", lat, 33);
        when = cyc;
    endtask

    task automatic expect_rate(input int n, input string tag);
        exp_t e;
        e.n = n; e.tag = tag;
        exp_q.push_back(e);
        wait (mon_busy);
        wait (!mon_busy);
    endtask

    // monitor: counts pulses over 32 cycles and measures gaps over 64 (R2, R3)
    initial begin
        forever begin
            exp_t e;
            int cnt, last, gmin, gmax, lo, hi;
            wait (exp_q.size() > 0);
            mon_busy = 1;
            e = exp_q[0];
            cnt = 0; last = -1; gmin = 1000; gmax = 0;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (clk_en) begin
                    if (i < 32) cnt++;
                    if (last >= 0) begin
                        if (i - last < gmin) gmin = i - last;
                        if (i - last > gmax) gmax = i - last;
                    end
                    last = i;
                end
            end
            void'(exp_q.pop_front());
            lo = 32 / e.n;
            hi = (32 + e.n - 1) / e.n;
            check(cnt == e.n, e.tag, "pulses per 32 cycles", cnt, e.n);
            check(gmin >= lo, "R3", "min pulse gap", gmin, lo);
            check(gmax <= hi, "R3", "max pulse gap", gmax, hi);
            mon_busy = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t_prev, t_now;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_reg(RATE, d); check(d == 0, "R1", "rate word after reset", d, 0);
        rd_reg(UPD, d);  check(d == 0, "R1", "update word after reset", d, 0);
        expect_rate(32, "R1");

        // R4: staged value without flag
        wr_reg(RATE, 32'd16 << 8);
        rd_reg(RATE, d); check(d[12:8] == 16, "R2", "rate field readback", d[12:8], 16);
        expect_rate(32, "R4");

        // R5: commit 16
        wr_reg(UPD, KICK);
        wait_clear("R5", t_prev);
        expect_rate(16, "R2");

        // R10 and R9 alignment
        wr_reg(RATE, 32'd31 << 8);
        wr_reg(UPD, KICK);
        wait_clear("R5", t_now);
        check((t_now - t_prev) % 32 == 0, "R9", "completion spacing mod 32", (t_now - t_prev) % 32, 0);
        t_prev = t_now;
        expect_rate(1, "R10");

        wr_reg(RATE, 32'd5 << 8);
        wr_reg(UPD, KICK);
        wait_clear("R5", t_now);
        check((t_now - t_prev) % 32 == 0, "R9", "completion spacing mod 32", (t_now - t_prev) % 32, 0);
        t_prev = t_now;
        expect_rate(27, "R2");

        wr_reg(RATE, 32'd20 << 8);
        wr_reg(UPD, KICK);
        wait_clear("R5", t_now);
        t_prev = t_now;
        expect_rate(12, "R3");

        // R8: unused bits stored and inert
        wr_reg(UPD, 32'h0000_5A3C);
        rd_reg(UPD, d); check(d == 32'h0000_5A3C, "R8", "update word spare bits", d, 32'h5A3C);
        expect_rate(12, "R8");
        wr_reg(RATE, 32'hC00A_03F7);
        wr_reg(UPD, 32'h8000_5A3C);
        wait_clear("R5", t_now);
        check((t_now - t_prev) % 32 == 0, "R9", "completion spacing mod 32", (t_now - t_prev) % 32, 0);
        rd_reg(UPD, d);  check(d == 32'h0000_5A3C, "R8", "update word after clear", d, 32'h5A3C);
        rd_reg(RATE, d); check(d == 32'hC00A_03F7, "R8", "rate word spare bits", d, 32'hC00A03F7);
        expect_rate(29, "R8");

        // realign, then R6 and R7 right after a completion
        wr_reg(UPD, KICK);
        wait_clear("R5", t_now);
        wr_reg(RATE, 32'd8 << 8);
        wr_reg(UPD, KICK);
        rd_reg(UPD, d); check(d[31] == 1'b1, "R5", "flag raised", d[31], 1);
        wr_reg(UPD, 32'h0);
        rd_reg(UPD, d); check(d[31] == 1'b1, "R6", "flag after zero write", d[31], 1);
        wr_reg(RATE, 32'd2 << 8);
        rd_reg(RATE, d); check(d[12:8] == 8, "R7", "field after busy write", d[12:8], 8);
        wait_clear("R5", t_now);
        expect_rate(24, "R7");

        wr_reg(RATE, 32'd0);
        wr_reg(UPD, KICK);
        wait_clear("R5", t_now);
        expect_rate(32, "R2");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule